// File: doc/BRIEF.md
# FEAC Code Qualifier with Maskable Interrupts

This block sits behind the overhead extractor of a line receiver. It takes the far-end alarm and control channel one bit at a time, marked by a bit enable. It finds 16-bit code words in that stream and keeps the last ten received 6-bit codes in a sliding history. A code that dominates the history becomes the validated message. The validated message is withdrawn once enough differing codes have arrived.

The host sees two 8-bit registers through a single-cycle read/write port. The code register (address 0) holds the most recently validated code. The control register (address 1) holds the interrupt enables, the clear-on-read status bits and a live flag that shows whether a message is currently validated. One active-low interrupt line combines both interrupt sources.

Top module: `feac_qualifier`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00 and `irq_n_o` is high.
- R2: A reception is counted only for the 16-bit serial sequence made of a 0, then code bits c0 to c5 (c0 first), then a 0, then eight 1s. A sequence whose ninth bit is 1 is not counted and changes no register.
- R3: When no message is validated and the newly received code fills at least 8 of the last 10 receptions, that code becomes validated and control bit 4 reads 1.
- R4: The code register reads the validated code in bits 6:1, with bits 7 and 0 at zero. It changes only when a new validation happens, and keeps its value after a removal.
- R5: When a message is validated and at least 3 of the last 10 receptions differ from it, the message is removed and control bit 4 reads 0.
- R6: A single reception never causes both a validation and a removal.
- R7: Control bit 1 enables the validation interrupt and bit 3 enables the removal interrupt; both are read/write. The status bits (bit 0 for validation, bit 2 for removal) are set only by an event that happens while the matching enable is 1.
- R8: A read of the control register clears both status bits. A read of the code register clears nothing.
- R9: `irq_n_o` is low exactly when some status bit and its enable are both 1. Clearing the enable or the status bit releases the line.
- R10: Bits 7:5 of the control register read zero. Writes to bits 0, 2 and 4 are ignored.
- R11: Seven matching receptions out of ten do not validate a code, and two differing receptions out of ten do not remove the validated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feac_bit_i | input | 1 | Serial channel data bit |
| feac_bit_en_i | input | 1 | Qualifies `feac_bit_i` in this cycle |
| addr_i | input | 1 | Register select: 0 = code, 1 = control |
| rd_en_i | input | 1 | Read strobe; clears status when addr_i is 1 |
| wr_en_i | input | 1 | Write strobe; only control bits 1 and 3 are stored |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest conditions to reach from the ports are the exact threshold edges of the sliding window. These occur when a history still holds codes from the previous message and the new code crosses 8 of 10, or a differing code reaches exactly its third occurrence. The bench sweeps all 64 codes in turn. For each code it first validates the code, then removes it with a different code, so every step begins from a history left behind by the step before. After every reception it compares both registers and the interrupt line against an arithmetic window model. This covers the seven-of-ten and two-of-ten boundaries and all four enable combinations.

// File: rtl/feac_pkg.sv
// Shared constants for the FEAC qualifier: register selects and control bit positions.
// Assumes a 6-bit code so that the code register layout fits in 8 bits.
package feac_pkg;
    localparam logic REG_CODE = 1'b0;
    localparam logic REG_CTRL = 1'b1;
    localparam int   CTL_VSTS = 0;
    localparam int   CTL_VEN  = 1;
    localparam int   CTL_RSTS = 2;
    localparam int   CTL_REN  = 3;
    localparam int   CTL_LIVE = 4;
endpackage

// File: rtl/feac_word_detect.sv
// Serial code word finder. Shifts in one bit per enabled cycle and pulses
// word_vld_o for one cycle when the last WORD_LEN bits form 0,c0..cN-1,0,1..1.
// Assumes GAP_ONES exceeds CODE_W, so no other alignment can match.
module feac_word_detect #(
    parameter int CODE_W   = 6,
    parameter int GAP_ONES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              bit_en_i,
    output logic              word_vld_o,
    output logic [CODE_W-1:0] word_code_o
);
    localparam int WORD_LEN = CODE_W + 2 + GAP_ONES;

    logic [WORD_LEN-1:0] sr_q;
    logic [WORD_LEN-1:0] sr_next;
    logic                hit;
    logic [CODE_W-1:0]   code_next;

    // Candidate window and pattern match after the incoming bit.
    always_comb begin
        sr_next = {sr_q[WORD_LEN-2:0], bit_i};
        hit = !sr_next[WORD_LEN-1] && !sr_next[GAP_ONES] && (&sr_next[GAP_ONES-1:0]);
        for (int i = 0; i < CODE_W; i++) begin
            code_next[i] = sr_next[WORD_LEN-2-i];
        end
    end

    // Shift register, reset to ones so that no stale zeros can form a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q        <= '1;
            word_vld_o  <= 1'b0;
            word_code_o <= '0;
        end else begin
            word_vld_o <= bit_en_i && hit;
            if (bit_en_i) begin
                sr_q <= sr_next;
                if (hit) word_code_o <= code_next;
            end
        end
    end

    // R2: two matches cannot come from adjacent cycles.
    a_r2_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/feac_window.sv
// Sliding history of the last WIN_LEN receptions. It validates a code that
// reaches VAL_THR copies while none is held, and removes the held code when
// REM_THR entries differ from it. Event outputs are one-cycle pulses.
// Assumes one reception at a time, indicated by word_vld_i.
module feac_window #(
    parameter int CODE_W  = 6,
    parameter int WIN_LEN = 10,
    parameter int VAL_THR = 8,
    parameter int REM_THR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld_i,
    input  logic [CODE_W-1:0] word_code_i,
    output logic              live_o,
    output logic [CODE_W-1:0] code_o,
    output logic              val_evt_o,
    output logic              rem_evt_o
);
    localparam int OLD_N = WIN_LEN - 1;
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic [CODE_W-1:0] hist_q [OLD_N];
    logic [OLD_N-1:0]  fill_q;
    logic [CNT_W-1:0]  same_cnt;
    logic [CNT_W-1:0]  diff_cnt;

    // Count matches with the new code and mismatches with the held code, over filled entries.
    always_comb begin
        same_cnt = CNT_W'(1);
        diff_cnt = (word_code_i != code_o) ? CNT_W'(1) : '0;
        for (int i = 0; i < OLD_N; i++) begin
            if (fill_q[i] && hist_q[i] == word_code_i) same_cnt = same_cnt + CNT_W'(1);
            if (fill_q[i] && hist_q[i] != code_o)      diff_cnt = diff_cnt + CNT_W'(1);
        end
    end

    // History shift and the decision, made once per reception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < OLD_N; i++) hist_q[i] <= '0;
            fill_q    <= '0;
            live_o    <= 1'b0;
            code_o    <= '0;
            val_evt_o <= 1'b0;
            rem_evt_o <= 1'b0;
        end else begin
            val_evt_o <= 1'b0;
            rem_evt_o <= 1'b0;
            if (word_vld_i) begin
                hist_q[0] <= word_code_i;
                for (int i = 1; i < OLD_N; i++) hist_q[i] <= hist_q[i-1];
                fill_q <= {fill_q[OLD_N-2:0], 1'b1};
                if (!live_o && same_cnt >= CNT_W'(VAL_THR)) begin
                    live_o    <= 1'b1;
                    code_o    <= word_code_i;
                    val_evt_o <= 1'b1;
                end else if (live_o && diff_cnt >= CNT_W'(REM_THR)) begin
                    live_o    <= 1'b0;
                    rem_evt_o <= 1'b1;
                end
            end
        end
    end

    // R6: never both events for one reception.
    a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(val_evt_o && rem_evt_o));
    // R3: a validation leaves the message held.
    a_r3_val_sets_live: assert property (@(posedge clk) disable iff (!rst_n)
        val_evt_o |-> live_o);
    // R5: a removal leaves no message held.
    a_r5_rem_drops_live: assert property (@(posedge clk) disable iff (!rst_n)
        rem_evt_o |-> !live_o);
    // R4: the held code only moves with a validation.
    a_r4_code_moves_on_val: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> val_evt_o);
endmodule

// File: rtl/feac_regs.sv
// Host-visible registers: code register, enables, clear-on-read status and the
// active-low interrupt. A status set wins over a read clear in the same cycle.
// Assumes single-cycle strobes and a combinational read path.
module feac_regs #(
    parameter int CODE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              live_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              val_evt_i,
    input  logic              rem_evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_n_o
);
    import feac_pkg::*;

    logic ven_q, ren_q, vsts_q, rsts_q;
    logic rd_ctrl;
    logic unused_wdata_bits;

    assign rd_ctrl           = rd_en_i && (addr_i == REG_CTRL);
    assign unused_wdata_bits = ^{wdata_i[DATA_W-1:4], wdata_i[CTL_RSTS], wdata_i[CTL_VSTS]};

    // Enables from writes; status from enabled events, cleared by control reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ven_q  <= 1'b0;
            ren_q  <= 1'b0;
            vsts_q <= 1'b0;
            rsts_q <= 1'b0;
        end else begin
            if (wr_en_i && addr_i == REG_CTRL) begin
                ven_q <= wdata_i[CTL_VEN];
                ren_q <= wdata_i[CTL_REN];
            end
            vsts_q <= (vsts_q && !rd_ctrl) || (val_evt_i && ven_q);
            rsts_q <= (rsts_q && !rd_ctrl) || (rem_evt_i && ren_q);
        end
    end

    // Read multiplexer for the two registers.
    always_comb begin
        rdata_o = '0;
        if (addr_i == REG_CODE) begin
            rdata_o[CODE_W:1] = code_i;
        end else begin
            rdata_o[CTL_VSTS] = vsts_q;
            rdata_o[CTL_VEN]  = ven_q;
            rdata_o[CTL_RSTS] = rsts_q;
            rdata_o[CTL_REN]  = ren_q;
            rdata_o[CTL_LIVE] = live_i;
        end
    end

    assign irq_n_o = !((vsts_q && ven_q) || (rsts_q && ren_q));

    // R7: a status bit rises only if its enable was set.
    a_r7_vsts_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsts_q) |-> $past(ven_q));
    a_r7_rsts_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsts_q) |-> $past(ren_q));
    // R8: a control read with no event pending clears both status bits.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !val_evt_i && !rem_evt_i) |=> (!vsts_q && !rsts_q));
endmodule

// File: rtl/feac_qualifier.sv
// Top level: serial code word finder, ten-deep qualification window and host
// registers. Assumes a clock-synchronous bit enable and host strobes.
module feac_qualifier #(
    parameter int CODE_W   = 6,
    parameter int GAP_ONES = 8,
    parameter int WIN_LEN  = 10,
    parameter int VAL_THR  = 8,
    parameter int REM_THR  = 3,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feac_bit_i,
    input  logic              feac_bit_en_i,
    input  logic              addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_n_o
);
    logic              word_vld;
    logic [CODE_W-1:0] word_code;
    logic              live;
    logic [CODE_W-1:0] held_code;
    logic              val_evt, rem_evt;

    feac_word_detect #(.CODE_W(CODE_W), .GAP_ONES(GAP_ONES)) u_detect (
        .clk(clk), .rst_n(rst_n), .bit_i(feac_bit_i), .bit_en_i(feac_bit_en_i),
        .word_vld_o(word_vld), .word_code_o(word_code));

    feac_window #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN), .VAL_THR(VAL_THR), .REM_THR(REM_THR)) u_window (
        .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld), .word_code_i(word_code),
        .live_o(live), .code_o(held_code), .val_evt_o(val_evt), .rem_evt_o(rem_evt));

    feac_regs #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .live_i(live), .code_i(held_code), .val_evt_i(val_evt),
        .rem_evt_i(rem_evt), .rdata_o(rdata_o), .irq_n_o(irq_n_o));

    // R9: the line is high right after reset.
    a_r9_irq_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> irq_n_o);
endmodule

// File: tb/sim_feac_qualifier.sv
// Self-checking bench: an arithmetic window model predicts the registers and the interrupt line after each reception.
module sim_feac_qualifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fbit = 1'b0, fen = 1'b0;
    logic       addr = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_n;

    always #10 clk = ~clk;

    feac_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .feac_bit_i(fbit), .feac_bit_en_i(fen),
        .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_n_o(irq_n));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int hist[10];
    int nfill = 0;
    bit m_live = 0, m_vsts = 0, m_rsts = 0, m_ven = 0, m_ren = 0;
    int m_code = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Window model: the count rules written straight from the requirements.
    task automatic model_push(int c);
        int same, diff;
        for (int i = 9; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = c;
        if (nfill < 10) nfill++;
        same = 0; diff = 0;
        for (int i = 0; i < nfill; i++) begin
            if (hist[i] == c) same++;
            if (hist[i] != m_code) diff++;
        end
        if (!m_live && same >= 8) begin
            m_live = 1; m_code = c;
            if (m_ven) m_vsts = 1;
        end else if (m_live && diff >= 3) begin
            m_live = 0;
            if (m_ren) m_rsts = 1;
        end
    endtask

    task automatic send_word(int c, bit bad);
        logic [15:0] seq;
        seq[15] = 1'b0;
        for (int i = 0; i < 6; i++) seq[14-i] = c[i];
        seq[8] = bad;
        seq[7:0] = 8'hFF;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); fen = 1'b1; fbit = seq[i];
        end
        @(negedge clk); fen = 1'b0; fbit = 1'b0;
        repeat (3) @(negedge clk);
        if (!bad) model_push(c);
    endtask

    task automatic check_state(string req);
        logic [7:0] exp_ctl;
        exp_ctl = {3'b000, m_live, m_ren, m_rsts, m_ven, m_vsts};
        addr = 1'b1; #1;
        chk({req, " ctrl"}, rdata, exp_ctl);
        addr = 1'b0; #1;
        chk({req, " code"}, rdata, {1'b0, m_code[5:0], 1'b0});
        chk({req, " irq_n"}, irq_n, !((m_vsts && m_ven) || (m_rsts && m_ren)));
    endtask

    task automatic read_reg(logic a);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        if (a) begin m_vsts = 0; m_rsts = 0; end
    endtask

    task automatic write_ctrl(logic [7:0] v);
        @(negedge clk); addr = 1'b1; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        m_ven = v[1]; m_ren = v[3];
    endtask

    initial begin
        int d, guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        write_ctrl(8'h0A);
        check_state("R7");
        // R2: broken words are ignored.
        for (int k = 0; k < 9; k++) send_word(5, 1'b1);
        check_state("R2");
        // R11: seven of ten matching does not validate.
        for (int k = 0; k < 7; k++) send_word(6'h15, 1'b0);
        check_state("R11");
        send_word(6'h15, 1'b0);
        check_state("R3");
        read_reg(1'b0);
        check_state("R8 code read keeps status");
        write_ctrl(8'h08);
        check_state("R9 enable off releases");
        write_ctrl(8'hFF);
        check_state("R10");
        read_reg(1'b1);
        check_state("R8");

        // Sweep every code: validate it, then remove it with another code.
        for (int c = 0; c < 64; c++) begin
            write_ctrl({4'b0000, 1'(c >> 1), 1'b0, 1'(c), 1'b0});
            d = (c + 37) % 64;
            guard = 0;
            while (m_live && guard < 12) begin
                send_word(d, 1'b0); check_state("R5 R11"); guard++;
            end
            guard = 0;
            while (!m_live && guard < 12) begin
                send_word(c, 1'b0); check_state("R3 R4 R11"); guard++;
            end
            chk("R3 validated", m_live, 1);
            guard = 0;
            while (m_live && guard < 12) begin
                send_word(d, 1'b0); check_state("R5 R6 R9"); guard++;
            end
            chk("R5 removed", m_live, 0);
            read_reg(1'b1);
            check_state("R8 R9");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule